// File: doc/BRIEF.md
# Programmable Logic Output Cell

This block is one output cell of a small sum-of-products programmable logic device. The AND array sits outside the block. The cell receives two groups of product terms and ORs each group into a sum term. Static configuration inputs set four things: whether the two sums are merged or kept apart, whether the storage element behaves as a data or a toggle flip-flop, which clock source drives it, and whether the pin shows the registered or the combinational value.

The flip-flop runs in the system clock domain. Its active edge is a rising edge of the selected clock source, either the cell's own clock product term or a dedicated input-pin clock, as sampled by the system clock. Each cell has its own asynchronous clear product term and its own output-enable product term. A synchronous preset, shared by all cells, acts on the active edge. A test preload port writes any value into the flip-flop. The flip-flop output always returns to the array as feedback, so a cell whose pin serves as an input can still hold buried state.

Top module: `pld_macrocell`

## Requirements
- R1: With `cfg_ttype`=0 (data mode), on an active edge with no clear, preload or preset, the flip-flop takes the data sum.
- R2: With `cfg_ttype`=1 (toggle mode), on such an edge the flip-flop inverts when the data sum is 1 and holds when it is 0.
- R3: The active edge is a rising edge, sampled on `clk`, of `clk_pt` when `cfg_pinclk`=0 or of `pin_clk` when `cfg_pinclk`=1. Edges on the unselected source have no effect. Without an active edge the flip-flop holds.
- R4: While `clr_pt` is 1, the flip-flop is 0 at once, without waiting for a clock. The clear outranks preload, preset and data.
- R5: On an active edge, `sync_preset`=1 sets the flip-flop to 1 and outranks the data sum. Without an edge it has no effect.
- R6: On any `clk` edge with `pl_en`=1 and no clear, the flip-flop loads `pl_val`. This happens with or without an active edge, and preload outranks preset and data.
- R7: With `cfg_sep`=0 (merged), the data sum and the combinational result are both (OR of `pt_a`) OR (OR of `pt_b`).
- R8: With `cfg_sep`=1 (split), the data sum is the OR of `pt_a` only, and the combinational result is the OR of `pt_b` only.
- R9: `pin_out` shows the flip-flop when `cfg_reg`=1 and the combinational result when `cfg_reg`=0. The pin is active high.
- R10: `pin_oe` equals `oe_pt` in every mode.
- R11: `fb` equals the flip-flop state in every mode, including while `pin_oe` is 0.
- R12: A synchronous active-low `rst_n` clears the flip-flop and the edge history, so after reset `fb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ttype | input | 1 | 0 data flip-flop, 1 toggle flip-flop |
| cfg_pinclk | input | 1 | 0 product-term clock, 1 input-pin clock |
| cfg_sep | input | 1 | 0 merged sums, 1 split sums |
| cfg_reg | input | 1 | 0 combinational pin, 1 registered pin |
| pt_a | input | PT_A | Product terms of the first sum |
| pt_b | input | PT_B | Product terms of the second sum |
| clk_pt | input | 1 | Clock product term of this cell |
| pin_clk | input | 1 | Dedicated input-pin clock |
| clr_pt | input | 1 | Asynchronous clear product term |
| oe_pt | input | 1 | Output-enable product term |
| sync_preset | input | 1 | Shared synchronous preset |
| pl_en | input | 1 | Test preload strobe |
| pl_val | input | 1 | Test preload value |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Flip-flop feedback to the array |

## Verification
Several state controls can fall in the same system cycle: clear with preload, preload with preset on an active edge, and preset with a toggle or data update. Directed cycles place each pair on one edge. Random cycles, with clear and preload as rare events, mix them with changes of clock source and mode. A bench model applies the priority order clear, preload, preset, update, and each cycle it compares `fb` and the pin against that model: once just after the inputs change, to catch the immediate clear, and again after the edge.

// File: rtl/pld_mc_pkg.sv
// Package pld_mc_pkg
// Shared configuration encodings for the output cell.
// Assumes each configuration bit is static while the cell is in use.
package pld_mc_pkg;
    typedef enum logic { FF_DATA = 1'b0, FF_TOGGLE = 1'b1 } ff_kind_e;
    typedef enum logic { CK_TERM = 1'b0, CK_PIN = 1'b1 } ck_src_e;
    typedef enum logic { SUM_MERGED = 1'b0, SUM_SPLIT = 1'b1 } sum_mode_e;
    typedef enum logic { PIN_COMB = 1'b0, PIN_REG = 1'b1 } pin_mode_e;
endpackage

// File: rtl/pld_mc_sum.sv
// Module pld_mc_sum
// ORs the two product-term groups into sums, then derives the flip-flop
// data input and the combinational result according to the sum mode.
// Assumes PT_A and PT_B are both at least 1.
module pld_mc_sum
    import pld_mc_pkg::*;
#(
    parameter int PT_A = 8,
    parameter int PT_B = 4
) (
    input  logic            sum_mode,
    input  logic [PT_A-1:0] terms_a,
    input  logic [PT_B-1:0] terms_b,
    output logic            d_sum,
    output logic            comb_sum
);
    logic sum_a;
    logic sum_b;

    // OR of each product-term group
    always_comb begin
        sum_a = |terms_a;
        sum_b = |terms_b;
    end

    // route sums to the flip-flop and to the combinational path
    always_comb begin
        if (sum_mode_e'(sum_mode) == SUM_SPLIT) begin
            d_sum    = sum_a;
            comb_sum = sum_b;
        end else begin
            d_sum    = sum_a | sum_b;
            comb_sum = sum_a | sum_b;
        end
    end
endmodule

// File: rtl/pld_mc_edge.sv
// Module pld_mc_edge
// Picks the clock source and detects its rising edge in the system clock
// domain, producing a one-cycle active-edge strobe.
// Assumes both sources are synchronous to clk or already synchronised.
module pld_mc_edge
    import pld_mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic term_clk,
    input  logic pin_clk,
    output logic act_edge
);
    logic sel_clk;
    logic sel_prev;

    // clock source multiplexer
    always_comb sel_clk = (ck_src_e'(src_sel) == CK_PIN) ? pin_clk : term_clk;

    // remember last sampled level of the chosen source
    always_ff @(posedge clk) begin
        if (!rst_n) sel_prev <= 1'b0;
        else        sel_prev <= sel_clk;
    end

    // rising edge of the chosen source
    always_comb act_edge = sel_clk & ~sel_prev;

    // R3
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_edge |=> !act_edge);
endmodule

// File: rtl/pld_mc_reg.sv
// Module pld_mc_reg
// The cell's storage element: asynchronous clear, preload, synchronous
// preset and data/toggle update, in that priority order.
// Assumes clr is a clean product term; the preload strobe acts on clk.
module pld_mc_reg
    import pld_mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kind,
    input  logic act_edge,
    input  logic d_in,
    input  logic clr,
    input  logic preset,
    input  logic pl_en,
    input  logic pl_val,
    output logic q
);
    logic q_upd;

    // next value on an active edge without overrides
    always_comb begin
        if (ff_kind_e'(kind) == FF_TOGGLE) q_upd = q ^ d_in;
        else                               q_upd = d_in;
    end

    // state register with clear > reset > preload > preset > update
    always_ff @(posedge clk or posedge clr) begin
        if (clr)              q <= 1'b0;
        else if (!rst_n)      q <= 1'b0;
        else if (pl_en)       q <= pl_val;
        else if (act_edge)    q <= preset ? 1'b1 : q_upd;
    end

    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (q == 1'b0));
    // R5
    preset_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_edge && preset && !pl_en && !clr) |=> (q || clr));
    // R2
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_edge && kind && d_in && !preset && !pl_en && !clr)
        |=> ((q != $past(q)) || clr));
    // R3
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_edge && !pl_en && !clr) |=> ($stable(q) || clr));
endmodule

// File: rtl/pld_macrocell.sv
// Module pld_macrocell
// One configurable output cell: sum combining, clock selection, storage
// element, pin multiplexer with enable, and array feedback.
// Assumes cfg_* inputs are static; the pad itself lives outside.
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int PT_A = 8,
    parameter int PT_B = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_ttype,
    input  logic            cfg_pinclk,
    input  logic            cfg_sep,
    input  logic            cfg_reg,
    input  logic [PT_A-1:0] pt_a,
    input  logic [PT_B-1:0] pt_b,
    input  logic            clk_pt,
    input  logic            pin_clk,
    input  logic            clr_pt,
    input  logic            oe_pt,
    input  logic            sync_preset,
    input  logic            pl_en,
    input  logic            pl_val,
    output logic            pin_out,
    output logic            pin_oe,
    output logic            fb
);
    logic d_sum;
    logic comb_sum;
    logic act_edge;
    logic q;

    pld_mc_sum #(.PT_A(PT_A), .PT_B(PT_B)) u_sum (
        .sum_mode (cfg_sep),
        .terms_a  (pt_a),
        .terms_b  (pt_b),
        .d_sum    (d_sum),
        .comb_sum (comb_sum)
    );

    pld_mc_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (cfg_pinclk),
        .term_clk (clk_pt),
        .pin_clk  (pin_clk),
        .act_edge (act_edge)
    );

    pld_mc_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (cfg_ttype),
        .act_edge (act_edge),
        .d_in     (d_sum),
        .clr      (clr_pt),
        .preset   (sync_preset),
        .pl_en    (pl_en),
        .pl_val   (pl_val),
        .q        (q)
    );

    // pin value, driver enable and feedback
    always_comb begin
        pin_out = (pin_mode_e'(cfg_reg) == PIN_REG) ? q : comb_sum;
        pin_oe  = oe_pt;
        fb      = q;
    end

    // R9
    reg_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reg |-> (pin_out == fb));
    // R8
    split_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sep && !cfg_reg) |-> (pin_out == (|pt_b)));
    // R7
    merged_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sep && !cfg_reg) |-> (pin_out == ((|pt_a) | (|pt_b))));
endmodule

// File: tb/pld_macrocell_bench.sv
module pld_macrocell_bench;
    localparam int PA = 8;
    localparam int PB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ttype = 0, cfg_pinclk = 0, cfg_sep = 0, cfg_reg = 0;
    logic [PA-1:0] pt_a = '0;
    logic [PB-1:0] pt_b = '0;
    logic clk_pt = 0, pin_clk = 0, clr_pt = 0, oe_pt = 0;
    logic sync_preset = 0, pl_en = 0, pl_val = 0;
    logic pin_out, pin_oe, fb;

    int n_chk = 0;
    int n_fail = 0;
    logic qm = 1'b0;
    logic prevm = 1'b0;
    string tag = "R12";

    always #2 clk = ~clk;

    pld_macrocell #(.PT_A(PA), .PT_B(PB)) u_pld_macrocell (
        .clk(clk), .rst_n(rst_n), .cfg_ttype(cfg_ttype), .cfg_pinclk(cfg_pinclk),
        .cfg_sep(cfg_sep), .cfg_reg(cfg_reg), .pt_a(pt_a), .pt_b(pt_b),
        .clk_pt(clk_pt), .pin_clk(pin_clk), .clr_pt(clr_pt), .oe_pt(oe_pt),
        .sync_preset(sync_preset), .pl_en(pl_en), .pl_val(pl_val),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
    );

    function automatic logic exp_comb();
        return cfg_sep ? (|pt_b) : ((|pt_a) | (|pt_b));
    endfunction

    function automatic logic exp_pin();
        return cfg_reg ? qm : exp_comb();
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_outputs();
        chk(tag, fb, qm);
        chk("R11", fb, qm);
        chk(cfg_reg ? "R9" : (cfg_sep ? "R8" : "R7"), pin_out, exp_pin());
        chk("R10", pin_oe, oe_pt);
    endtask

    // inputs already driven at a negedge; runs one cycle, ends at negedge
    task automatic tick();
        logic sel, e, dm;
        #1;
        if (clr_pt) begin
            qm = 1'b0;
            chk("R4", fb, 1'b0);
        end
        @(posedge clk);
        sel = cfg_pinclk ? pin_clk : clk_pt;
        e = sel & ~prevm;
        prevm = sel;
        dm = cfg_sep ? (|pt_a) : ((|pt_a) | (|pt_b));
        if (clr_pt) begin qm = 1'b0; tag = "R4"; end
        else if (pl_en) begin qm = pl_val; tag = "R6"; end
        else if (e) begin
            if (sync_preset) begin qm = 1'b1; tag = "R5"; end
            else if (cfg_ttype) begin qm = qm ^ dm; tag = "R2"; end
            else begin qm = dm; tag = "R1"; end
        end else tag = "R3";
        @(negedge clk);
        chk_outputs();
    endtask

    task automatic quiet();
        clk_pt = 0; pin_clk = 0; clr_pt = 0; sync_preset = 0; pl_en = 0;
        pl_val = 0; pt_a = '0; pt_b = '0;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        chk("R12", fb, 1'b0);
        rst_n = 1'b1;
        tag = "R12";
        tick();
        // R1 data mode via product-term clock
        pt_a = 8'h10; clk_pt = 1; tick();
        clk_pt = 0; pt_a = '0; tick();
        clk_pt = 1; tick();
        // R2 toggle mode: two toggles, then a hold with zero data
        quiet(); cfg_ttype = 1; tick();
        pt_b = 4'h2; clk_pt = 1; tick();
        clk_pt = 0; tick(); clk_pt = 1; tick();
        clk_pt = 0; pt_b = '0; tick(); clk_pt = 1; tick();
        // R3 pin clock selected: term edge ignored, pin edge acts
        quiet(); cfg_ttype = 0; cfg_pinclk = 1; pt_a = 8'h01; tick();
        clk_pt = 1; tick();
        pin_clk = 1; tick();
        // R4 clear beats preload in the same cycle
        quiet(); clr_pt = 1; pl_en = 1; pl_val = 1; tick();
        // R6 preload beats preset on an active edge
        quiet(); tick();
        pin_clk = 1; sync_preset = 1; pl_en = 1; pl_val = 0; tick();
        // R5 preset beats zero data on an edge
        quiet(); tick();
        pin_clk = 1; sync_preset = 1; tick();
        // R8 split comb pin and R11 feedback with pin disabled
        quiet(); cfg_sep = 1; cfg_reg = 0; oe_pt = 0; pt_b = 4'h8; tick();
        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ((i % 250) == 0) begin
                cfg_ttype = $urandom; cfg_pinclk = $urandom;
                cfg_sep = $urandom; cfg_reg = $urandom;
            end
            pt_a = ($urandom % 3 == 0) ? PA'($urandom) : '0;
            pt_b = ($urandom % 3 == 0) ? PB'($urandom) : '0;
            clk_pt = $urandom; pin_clk = $urandom; oe_pt = $urandom;
            clr_pt = ($urandom % 16 == 0);
            pl_en = ($urandom % 12 == 0); pl_val = $urandom;
            sync_preset = ($urandom % 6 == 0);
            tick();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule